// File: doc/BRIEF.md
# Serial Access Register with Tap Pointer

This block is a 256-byte serial access buffer that sits beside a dynamic memory array. A transfer controller fills it from one memory row, or drains it back into a row, through a byte-wide row port. It then issues a transfer command. The command sets the direction of the serial port and loads a start tap into the serial pointer. After that, each serial clock edge reads or writes one byte at the pointer and moves the pointer forward by one. The pointer wraps from the last entry back to entry 0.

Serial clock edges reach the block as a single-cycle strobe that is already synchronised to `clk`. A serial block input suppresses serial data access and the output enable, but the pointer keeps stepping. The serial port starts in input mode after reset. Until the first transfer command arrives, the pointer holds no valid position.

Top module: `serial_access_reg`

## Requirements
- R1: After reset, `mode_in`=1, `ptr_valid`=0, `sout_en`=0 and `sclk_err`=0.
- R2: A command with `cmd_kind`=2'b01 (load from row) sets output mode (`mode_in`=0), sets `ptr_out` to `cmd_tap` and sets `ptr_valid`=1, all on the same edge.
- R3: A command with `cmd_kind`=2'b10 (store to row) or 2'b11 (mode only) sets input mode and loads `cmd_tap` into the pointer. A command never changes the stored bytes. `cmd_kind`=2'b00 has no effect.
- R4: An accepted serial strobe advances `ptr_out` by one on that edge, and the pointer wraps from 255 to 0.
- R5: In output mode with `ser_block`=0, an accepted strobe places the byte at the pre-step pointer on `sout_data` on that edge. Otherwise `sout_data` holds its value.
- R6: In input mode with `ser_block`=0, an accepted strobe writes `sin_data` into the byte at the pre-step pointer.
- R7: With `ser_block`=1, a strobe writes nothing and leaves `sout_data` unchanged, but the pointer still advances.
- R8: A strobe that arrives while `xfer_busy`=1 or `cmd_valid`=1 does not move the pointer and writes nothing. It raises `sclk_err` for exactly the following cycle.
- R9: When a command and a strobe arrive in the same cycle, the pointer takes `cmd_tap`.
- R10: `row_we` writes `row_wdata` at `row_addr`. `row_re` returns the byte at `row_addr` on `row_rdata` after the edge.
- R11: Strobes that arrive before any transfer command are ignored: the pointer stays invalid and no error is raised.
- R12: `sout_en` is registered and equals (output mode and pointer valid and `ser_block`=0), taken from the state before each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_busy | input | 1 | Transfer controller is using the row port |
| cmd_valid | input | 1 | Transfer command strobe |
| cmd_kind | input | 2 | 01 load, 10 store, 11 mode only, 00 none |
| cmd_tap | input | 8 | Start tap for the pointer |
| row_we | input | 1 | Row port byte write |
| row_re | input | 1 | Row port byte read |
| row_addr | input | 8 | Row port byte index |
| row_wdata | input | 8 | Row port write data |
| row_rdata | output | 8 | Row port read data, registered |
| sclk_pulse | input | 1 | Serial clock rising edge strobe |
| ser_block | input | 1 | High blocks serial data access |
| sin_data | input | 8 | Serial input byte |
| sout_data | output | 8 | Serial output byte, registered |
| sout_en | output | 1 | Serial output enable, registered |
| ptr_out | output | 8 | Current serial pointer |
| ptr_valid | output | 1 | Pointer holds a loaded position |
| mode_in | output | 1 | 1 input mode, 0 output mode |
| sclk_err | output | 1 | One-cycle flag for a rejected strobe |

## Verification
Every result in this block is due on the edge that samples its stimulus: the pointer, the mode, `sout_data`, `row_rdata` and `sclk_err` all change on that edge. The exception is `sout_en`, which reflects the mode from before the edge, so a mode change shows up one edge later. The bench drives inputs just after an edge and compares outputs one time unit after the following edge. A write from the serial side is confirmed by a row port read issued afterwards, one edge later. The sweeps walk the pointer across the wrap with data derived arithmetically from the index.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    XK_NONE  = 2'b00,
    XK_LOAD  = 2'b01,
    XK_STORE = 2'b10,
    XK_MODE  = 2'b11
  } xfer_kind_e;
endpackage

// File: rtl/sar_store.sv
module sar_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // both write ports share one process; serial and row writes never coincide
  // because serial access is rejected while the controller is busy
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       a_rdata <= '0;
    else if (a_en) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)       b_rdata <= '0;
    else if (b_re) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/sar_pointer.sv
module sar_pointer
  import sar_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  xfer_kind_e        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_tap,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic              valid,
  output logic              mode_in
);
  logic cmd_take;
  assign cmd_take = cmd_valid && (cmd_kind != XK_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      valid   <= 1'b0;
      mode_in <= 1'b1;
    end else if (cmd_take) begin
      ptr     <= cmd_tap;
      valid   <= 1'b1;
      mode_in <= (cmd_kind != XK_LOAD);
    end else if (step) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sar_gate.sv
module sar_gate (
  input  logic clk,
  input  logic rst,
  input  logic sclk_pulse,
  input  logic xfer_busy,
  input  logic cmd_valid,
  input  logic ptr_valid,
  input  logic mode_in,
  input  logic ser_block,
  output logic step,
  output logic wr_en,
  output logic rd_en,
  output logic sout_en,
  output logic err
);
  logic reject;
  assign reject = sclk_pulse && (xfer_busy || cmd_valid);
  assign step   = sclk_pulse && !xfer_busy && !cmd_valid && ptr_valid;
  assign wr_en  = step && mode_in && !ser_block;
  assign rd_en  = step && !mode_in && !ser_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      err     <= 1'b0;
      sout_en <= 1'b0;
    end else begin
      err     <= reject;
      sout_en <= !mode_in && ptr_valid && !ser_block;
    end
  end
endmodule

// File: rtl/serial_access_reg.sv
module serial_access_reg
  import sar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_busy,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_tap,
  input  logic              row_we,
  input  logic              row_re,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic [DATA_W-1:0] row_wdata,
  output logic [DATA_W-1:0] row_rdata,
  input  logic              sclk_pulse,
  input  logic              ser_block,
  input  logic [DATA_W-1:0] sin_data,
  output logic [DATA_W-1:0] sout_data,
  output logic              sout_en,
  output logic [ADDR_W-1:0] ptr_out,
  output logic              ptr_valid,
  output logic              mode_in,
  output logic              sclk_err
);
  logic step, wr_en, rd_en;

  sar_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .cmd_kind(xfer_kind_e'(cmd_kind)), .cmd_tap(cmd_tap), .step(step),
    .ptr(ptr_out), .valid(ptr_valid), .mode_in(mode_in)
  );

  sar_gate u_gate (
    .clk(clk), .rst(rst), .sclk_pulse(sclk_pulse), .xfer_busy(xfer_busy),
    .cmd_valid(cmd_valid), .ptr_valid(ptr_valid), .mode_in(mode_in),
    .ser_block(ser_block), .step(step), .wr_en(wr_en), .rd_en(rd_en),
    .sout_en(sout_en), .err(sclk_err)
  );

  sar_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst),
    .a_en(rd_en), .a_we(wr_en), .a_addr(ptr_out), .a_wdata(sin_data),
    .a_rdata(sout_data),
    .b_we(row_we), .b_re(row_re), .b_addr(row_addr), .b_wdata(row_wdata),
    .b_rdata(row_rdata)
  );
endmodule

// File: rtl/sar_checks.sv
module sar_checks #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_busy,
  input logic              cmd_valid,
  input logic [1:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_tap,
  input logic              sclk_pulse,
  input logic              ser_block,
  input logic [DATA_W-1:0] sout_data,
  input logic              sout_en,
  input logic [ADDR_W-1:0] ptr_out,
  input logic              ptr_valid,
  input logic              mode_in,
  input logic              sclk_err
);
  p_cmd_tap_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind != 2'b00 |=> ptr_out == $past(cmd_tap) && ptr_valid);
  p_load_mode_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind == 2'b01 |=> !mode_in);
  p_in_mode_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind[1] |=> mode_in);
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    sclk_pulse && !xfer_busy && !cmd_valid && ptr_valid
      |=> ptr_out == ADDR_W'($past(ptr_out) + 1'b1));
  p_sout_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sclk_pulse |=> $stable(sout_data));
  p_block_data_r7: assert property (@(posedge clk) disable iff (rst)
    ser_block |=> $stable(sout_data));
  p_block_oe_r7: assert property (@(posedge clk) disable iff (rst)
    ser_block |=> !sout_en);
  p_err_r8: assert property (@(posedge clk) disable iff (rst)
    sclk_pulse && (xfer_busy || cmd_valid) |=> sclk_err);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    sclk_pulse && xfer_busy && !cmd_valid |=> $stable(ptr_out) && $stable(ptr_valid));
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !ptr_valid && !cmd_valid |=> !ptr_valid);
endmodule

bind serial_access_reg sar_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .xfer_busy(xfer_busy), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .cmd_tap(cmd_tap), .sclk_pulse(sclk_pulse),
  .ser_block(ser_block), .sout_data(sout_data), .sout_en(sout_en),
  .ptr_out(ptr_out), .ptr_valid(ptr_valid), .mode_in(mode_in),
  .sclk_err(sclk_err)
);

// File: tb/sim_serial_access_reg.sv
module sim_serial_access_reg;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_busy = 0, cmd_valid = 0, row_we = 0, row_re = 0;
  logic sclk_pulse = 0, ser_block = 0;
  logic [1:0] cmd_kind = 0;
  logic [AW-1:0] cmd_tap = 0, row_addr = 0;
  logic [DW-1:0] row_wdata = 0, sin_data = 0;
  logic [DW-1:0] row_rdata, sout_data;
  logic sout_en, ptr_valid, mode_in, sclk_err;
  logic [AW-1:0] ptr_out;

  int nchk = 0, nfail = 0;
  logic [DW-1:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_access_reg #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .xfer_busy(xfer_busy), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_tap(cmd_tap), .row_we(row_we), .row_re(row_re),
    .row_addr(row_addr), .row_wdata(row_wdata), .row_rdata(row_rdata),
    .sclk_pulse(sclk_pulse), .ser_block(ser_block), .sin_data(sin_data),
    .sout_data(sout_data), .sout_en(sout_en), .ptr_out(ptr_out),
    .ptr_valid(ptr_valid), .mode_in(mode_in), .sclk_err(sclk_err)
  );

  function automatic logic [DW-1:0] fill_val(int i);
    return DW'((i * 37 + 5) % 256);
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic command(logic [1:0] kind, logic [AW-1:0] tap, logic pulse);
    cmd_valid = 1; cmd_kind = kind; cmd_tap = tap; sclk_pulse = pulse;
    tick();
    cmd_valid = 0; cmd_kind = 0; sclk_pulse = 0;
  endtask

  task automatic row_read_all(string req);
    for (int i = 0; i < N; i++) begin
      row_re = 1; row_addr = AW'(i);
      tick();
      chk(req, row_rdata, model[i]);
    end
    row_re = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int p;
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R1 mode_in", mode_in, 1);
    chk("R1 ptr_valid", ptr_valid, 0);
    chk("R1 sout_en", sout_en, 0);
    chk("R1 sclk_err", sclk_err, 0);

    // strobe before any command
    sclk_pulse = 1; sin_data = 8'hEE; tick(); sclk_pulse = 0;
    chk("R11 ptr_valid", ptr_valid, 0);
    chk("R11 no error", sclk_err, 0);

    // controller fills the buffer (R10)
    xfer_busy = 1;
    for (int i = 0; i < N; i++) begin
      row_we = 1; row_addr = AW'(i); row_wdata = fill_val(i); model[i] = fill_val(i);
      tick();
    end
    row_we = 0;
    row_read_all("R10 row readback");
    sclk_pulse = 1; tick(); sclk_pulse = 0;
    chk("R8 error while busy", sclk_err, 1);
    chk("R8 pointer untouched", ptr_valid, 0);
    tick();
    chk("R8 error lasts one cycle", sclk_err, 0);
    xfer_busy = 0;

    // load command, tap near the top to cross the wrap
    command(2'b01, 8'd250, 0);
    chk("R2 ptr", ptr_out, 250);
    chk("R2 valid", ptr_valid, 1);
    chk("R2 output mode", mode_in, 0);
    tick();
    chk("R12 enable", sout_en, 1);

    p = 250;
    begin
      logic [DW-1:0] last;
      last = sout_data;
      for (int k = 0; k < 260; k++) begin
        logic blk;
        blk = (k % 9) == 4;
        sclk_pulse = 1; ser_block = blk;
        tick();
        sclk_pulse = 0; ser_block = 0;
        if (blk) chk("R7 output held", sout_data, last);
        else     chk("R5 output byte", sout_data, model[p]);
        chk("R12 enable follows block", sout_en, blk ? 0 : 1);
        p = (p + 1) % N;
        chk("R4 pointer step/wrap", ptr_out, p);
        last = sout_data;
      end
    end

    // command and strobe in one cycle: command wins
    command(2'b10, 8'd3, 1);
    chk("R9 tap wins", ptr_out, 3);
    chk("R8 error on command cycle", sclk_err, 1);
    chk("R3 input mode", mode_in, 0 + 1);
    tick();
    chk("R12 disabled in input mode", sout_en, 0);

    // serial writes with periodic blocking
    p = 3;
    for (int k = 0; k < N; k++) begin
      logic blk;
      blk = (k % 5) == 2;
      sclk_pulse = 1; ser_block = blk; sin_data = DW'(k ^ 8'h5A);
      tick();
      sclk_pulse = 0; ser_block = 0;
      if (!blk) model[p] = DW'(k ^ 8'h5A);
      p = (p + 1) % N;
      chk("R7 pointer steps when blocked", ptr_out, p);
    end

    // rejected strobe while busy must not write
    xfer_busy = 1; sclk_pulse = 1; sin_data = 8'h00; tick();
    sclk_pulse = 0; xfer_busy = 0;
    chk("R8 pointer held", ptr_out, p);

    // mode-only command and a null command
    command(2'b11, 8'd100, 0);
    chk("R3 mode-only tap", ptr_out, 100);
    chk("R3 mode-only input", mode_in, 1);
    command(2'b00, 8'd7, 0);
    chk("R3 null command ignored", ptr_out, 100);
    row_read_all("R6 serial write contents");

    command(2'b01, 8'd0, 0);
    chk("R2 back to output", mode_in, 0);
    sclk_pulse = 1; tick(); sclk_pulse = 0;
    chk("R5 first byte", sout_data, model[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule